// File: doc/BRIEF.md
# Loss-of-Signal Detector with Clock Substitution

This block watches the recovered receive bit stream. It takes one bit on each rising edge of the recovered clock and counts how many zero bits (spaces) have arrived in a row. When the run of zeros reaches a programmable threshold (175 by default), it raises a loss-of-signal alarm. The first one bit (mark) that follows clears the alarm.

The alarm also chooses the receive clock that the block sends downstream. While the line is healthy, that clock is the recovered clock. While the alarm is up, it is a reference clock: the master clock when a strap input says one is fitted, and otherwise a local crystal-derived clock. The change between the recovered clock and the reference clock in either direction goes through a glitch-free multiplexer, so downstream logic keeps a clean clock during the change.

Top module: `los_clk_monitor`

## Requirements
- R1: The alarm `los` is low after 174 consecutive zeros. It is high after the rising `rx_clk` edge that samples the 175th consecutive zero (threshold parameter `THRESH`, default 175).
- R2: A one on `rx_data` clears `los` at the same rising `rx_clk` edge that samples it.
- R3: A one received before the threshold restarts the zero run from zero. 174 zeros, then a one, then 174 zeros leave `los` low throughout.
- R4: While zeros continue past the threshold, the run count saturates and does not wrap. `los` stays high through at least 295 consecutive zeros.
- R5: A synchronous reset `rst`, held for several cycles of every clock, clears the run count and `los` and selects the recovered clock as `rclk_out`.
- R6: While `los` is high and `mclk_present` is 1, `rclk_out` carries `mclk` once the switchover has settled.
- R7: While `los` is high and `mclk_present` is 0, `rclk_out` carries `xclk` once the switchover has settled.
- R8: No high or low phase of `rclk_out` is shorter than the shortest half period of the two clocks being switched. The enables of the two sources are never on together.
- R9: After `los` clears, `rclk_out` returns to `rx_clk` once the switchover has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 1 | Recovered data bit, 1 = mark, 0 = space |
| mclk | input | 1 | Master reference clock |
| mclk_present | input | 1 | Strap, 1 when the master clock is fitted |
| xclk | input | 1 | Crystal-derived fallback clock |
| los | output | 1 | Loss-of-signal alarm |
| rclk_out | output | 1 | Selected receive clock |

## Verification
The assertions assume that `rx_data` changes only away from the rising edge of `rx_clk`. They also assume that `rst` is held long enough to reach every clock domain, and that `mclk_present` changes only while reset is held. The bench drives data on the falling edge of the recovered clock and holds reset for six recovered cycles. It moves the strap only inside a reset, then measures the edge count and the phase widths of the output clock against the source that should be selected.

// File: rtl/los_pkg.sv
`timescale 1ns/1ps
package los_pkg;
   typedef enum logic {
      SRC_RECOVERED  = 1'b0,
      SRC_REFERENCE  = 1'b1
   } clk_src_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/los_run_counter.sv
`timescale 1ns/1ps
module los_run_counter #(
   parameter int unsigned THRESH = 175
) (
   input  logic clk,
   input  logic rst,
   input  logic data,
   output logic alarm
);
   localparam int unsigned CW = los_pkg::cnt_width(THRESH);
   localparam logic [CW-1:0] LIMIT = CW'(THRESH);

   initial begin
      if (THRESH < 2) $error("THRESH must be at least 2");
   end

   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
         alarm <= 1'b0;
      end else if (data) begin
         run_q <= '0;
         alarm <= 1'b0;
      end else if (run_q != LIMIT) begin
         run_q <= run_q + 1'b1;
         alarm <= (run_q == LIMIT - 1'b1);
      end
   end

   p_reset_r5: assert property (@(posedge clk) rst |=> (!alarm && run_q == '0));
   p_mark_clears_r2: assert property (@(posedge clk) disable iff (rst)
      data |=> (!alarm && run_q == '0));
   p_zero_step_r3: assert property (@(posedge clk) disable iff (rst)
      (!data && run_q != LIMIT) |=> (run_q == $past(run_q) + 1'b1));
   p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      (!data && run_q == LIMIT) |=> (run_q == LIMIT && alarm));
   p_rise_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(alarm) |-> (run_q == LIMIT));
endmodule

// File: rtl/los_ref_pick.sv
`timescale 1ns/1ps
module los_ref_pick #(
   parameter bit XTAL_FALLBACK = 1'b1
) (
   input  logic mclk,
   input  logic xclk,
   input  logic present,
   output logic ref_clk
);
   generate
      if (XTAL_FALLBACK) begin : g_fallback
         assign ref_clk = present ? mclk : xclk;
      end else begin : g_master_only
         logic unused_sigs;
         assign unused_sigs = xclk ^ present;
         assign ref_clk = mclk;
      end
   endgenerate
endmodule

// File: rtl/los_clk_branch.sv
`timescale 1ns/1ps
module los_clk_branch #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic want,
   input  logic other_en,
   output logic en
);
   localparam int unsigned NPOS = STAGES - 1;

   initial begin
      if (STAGES < 2) $error("STAGES must be at least 2");
   end

   logic [NPOS-1:0] chain;

   generate
      for (genvar g = 0; g < NPOS; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[g] <= RST_VAL;
               else     chain[g] <= want & ~other_en;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[g] <= RST_VAL;
               else     chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(negedge clk) begin
      if (rst) en <= RST_VAL;
      else     en <= chain[NPOS-1];
   end
endmodule

// File: rtl/los_clk_switch.sv
`timescale 1ns/1ps
module los_clk_switch #(
   parameter int unsigned STAGES = 2
) (
   input  logic           clk_rec,
   input  logic           clk_ref,
   input  logic           rst,
   input  los_pkg::clk_src_e sel,
   output logic           clk_out
);
   logic [1:0] clks;
   logic [1:0] en;

   assign clks = {clk_ref, clk_rec};

   generate
      for (genvar i = 0; i < 2; i++) begin : g_branch
         los_clk_branch #(
            .STAGES  (STAGES),
            .RST_VAL (i == 0)
         ) u_branch (
            .clk      (clks[i]),
            .rst      (rst),
            .want     (sel == los_pkg::clk_src_e'(i)),
            .other_en (en[1-i]),
            .en       (en[i])
         );
      end
   endgenerate

   assign clk_out = |(clks & en);

   always_comb begin
      if (!rst && !$isunknown(en)) begin
         p_one_enable_r8: assert (en != 2'b11)
            else $error("both clock enables on");
      end
   end
endmodule

// File: rtl/los_clk_monitor.sv
`timescale 1ns/1ps
module los_clk_monitor #(
   parameter int unsigned THRESH        = 175,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          XTAL_FALLBACK = 1'b1
) (
   input  logic rx_clk,
   input  logic rst,
   input  logic rx_data,
   input  logic mclk,
   input  logic mclk_present,
   input  logic xclk,
   output logic los,
   output logic rclk_out
);
   logic ref_clk;
   los_pkg::clk_src_e sel;

   los_run_counter #(.THRESH(THRESH)) u_count (
      .clk   (rx_clk),
      .rst   (rst),
      .data  (rx_data),
      .alarm (los)
   );

   los_ref_pick #(.XTAL_FALLBACK(XTAL_FALLBACK)) u_pick (
      .mclk    (mclk),
      .xclk    (xclk),
      .present (mclk_present),
      .ref_clk (ref_clk)
   );

   assign sel = los ? los_pkg::SRC_REFERENCE : los_pkg::SRC_RECOVERED;

   los_clk_switch #(.STAGES(SYNC_STAGES)) u_switch (
      .clk_rec (rx_clk),
      .clk_ref (ref_clk),
      .rst     (rst),
      .sel     (sel),
      .clk_out (rclk_out)
   );
endmodule

// File: tb/los_clk_monitor_tb.sv
`timescale 1ns/1ps
module los_clk_monitor_tb;
   typedef struct {
      bit    exp;
      string tag;
   } item_t;

   logic rx_clk = 0, mclk = 0, xclk = 0;
   logic rst = 1, rx_data = 1, mclk_present = 1;
   logic los, rclk_out;

   int checks = 0, fails = 0;
   int model_cnt = 0;
   item_t q[$];
   bit win = 0, mon_on = 0;
   int n_out, n_rx, n_m, n_x;
   int runts = 0;
   realtime last_t;

   always #10 rx_clk = ~rx_clk;
   initial begin #3; forever #7 mclk = ~mclk; end
   initial begin #1; forever #15 xclk = ~xclk; end

   los_clk_monitor u_dut (
      .rx_clk(rx_clk), .rst(rst), .rx_data(rx_data), .mclk(mclk),
      .mclk_present(mclk_present), .xclk(xclk), .los(los), .rclk_out(rclk_out)
   );

   always @(posedge rclk_out) if (win) n_out++;
   always @(posedge rx_clk)   if (win) n_rx++;
   always @(posedge mclk)     if (win) n_m++;
   always @(posedge xclk)     if (win) n_x++;

   // R8: every phase of the output clock is at least 6 ns wide
   always @(rclk_out) begin
      if (mon_on) begin
         if ($realtime - last_t < 6.0) runts++;
      end
      last_t = $realtime;
   end

   task automatic check(input bit cond, input string tag, input int act, input int exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // scoreboard monitor: one expected alarm value per sampled bit
   initial begin
      forever begin
         @(posedge rx_clk);
         #5;
         if (q.size() != 0) begin
            item_t it;
            it = q.pop_front();
            check(los === it.exp, it.tag, int'(los), int'(it.exp));
         end
      end
   end

   task automatic send_bit(input bit b, input string tag);
      item_t it;
      @(negedge rx_clk);
      rx_data = b;
      if (b) model_cnt = 0;
      else if (model_cnt < 175) model_cnt++;
      it.exp = (model_cnt == 175);
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic send_run(input bit b, input int n, input string tag);
      for (int i = 0; i < n; i++) send_bit(b, tag);
   endtask

   task automatic do_reset(input bit strap);
      mon_on = 0;
      @(negedge rx_clk);
      rst = 1;
      rx_data = 1;
      repeat (3) @(negedge rx_clk);
      mclk_present = strap;
      repeat (3) @(negedge rx_clk);
      rst = 0;
      model_cnt = 0;
      repeat (4) @(negedge rx_clk);
      mon_on = 1;
   endtask

   // which: 0 = rx_clk, 1 = mclk, 2 = xclk
   task automatic follow(input bit b, input int which, input string tag);
      int r;
      send_run(b, 20, tag);
      n_out = 0; n_rx = 0; n_m = 0; n_x = 0;
      win = 1;
      send_run(b, 100, tag);
      win = 0;
      r = (which == 0) ? n_rx : (which == 1) ? n_m : n_x;
      check((n_out - r) <= 1 && (r - n_out) <= 1, tag, n_out, r);
   endtask

   initial begin
      #2_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      do_reset(1'b1);
      check(los === 1'b0, "R5 reset alarm", int'(los), 0);
      follow(1'b1, 0, "R5 recovered clock after reset");

      // R3: interrupted runs never alarm
      send_run(1'b0, 174, "R3 run below threshold");
      send_bit(1'b1, "R3 mark restarts run");
      send_run(1'b0, 174, "R3 second run below threshold");
      send_bit(1'b1, "R3 mark");

      // R1: boundary at 174 and 175
      send_run(1'b0, 174, "R1 174 zeros");
      send_bit(1'b0, "R1 175th zero");

      // R4 and R6: long run with master clock selected
      follow(1'b0, 1, "R6 master clock under alarm");
      send_run(1'b0, 60, "R4 saturate no wrap");

      // R2 and R9
      send_bit(1'b1, "R2 first mark clears");
      follow(1'b1, 0, "R9 back to recovered clock");

      // R5 mid-alarm reset, then R7 with no master clock
      send_run(1'b0, 180, "R1 alarm before reset");
      do_reset(1'b0);
      check(los === 1'b0, "R5 reset clears alarm", int'(los), 0);
      send_run(1'b0, 175, "R1 threshold with fallback");
      follow(1'b0, 2, "R7 crystal clock under alarm");
      send_bit(1'b1, "R2 mark clears");
      follow(1'b1, 0, "R9 recovered after fallback");

      repeat (3) @(negedge rx_clk);
      check(runts == 0, "R8 no runt phase", runts, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule